// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block runs the host side of a 12-bit sampling converter that returns its result over a serial line. A frame starts when the controller drives the active-low select line low. After a short setup time it sends 16 serial-clock pulses. It samples the returned data line at every falling clock edge. When the frame ends it releases select and presents the 12-bit value together with a one-cycle valid strobe. Each frame carries four leading bits that must read as zero. If any of them reads as one, the result is flagged as a framing error.

Frames are started in one of two ways. In single-shot mode a pulse on the start input requests one frame. In continuous mode frames repeat at a programmed period, counted in system clocks. The serial-clock half period is also programmed in system clocks. After every frame, the select line must stay high for a quiet window and an acquisition window. These windows are minimum times in nanoseconds, and the controller converts them into system-clock counts from its clock-period parameter. If the programmed half period and frame period cannot meet both windows, the controller flags the setting as invalid and starts no frames.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, select is high, the serial clock is high and valid is low.
- R2: Select stays low for exactly SETUP + 32·div system clocks per frame, where SETUP is 2 cycles at a 5 ns clock. During that time the serial clock falls exactly 16 times. The serial clock is high in every cycle in which select is high.
- R3: The first serial-clock falling edge comes SETUP cycles (at least 10 ns) after select falls. After that, every low phase and every high phase of the serial clock lasts exactly div system clocks, including the final high phase before select rises.
- R4: The data line is sampled at each falling serial-clock edge, and the n-th sample is frame bit n. Bits 5 to 16 form the result, most significant bit first, and result_o carries that value.
- R5: valid_o is a one-cycle pulse. It is high in the first cycle in which select is high again after a frame.
- R6: frame_err_o is high together with valid_o exactly when any of frame bits 1 to 4 was sampled as 1. In every other cycle it is low.
- R7: Between frames, select stays high for at least G cycles. G is the smallest count that meets both conditions: at least 50 ns high, and 2.5 serial-clock periods + 36 ns + the high time ≥ 250 ns. With start held high in single-shot mode, select stays high for exactly G cycles.
- R8: In continuous mode, consecutive falling edges of select are exactly period_i system clocks apart.
- R9: A setting with div_i = 0, or with period_i < SETUP + 32·div + G, raises cfg_err_o one cycle later and starts no frame. A period exactly equal to that bound is accepted.
- R10: A start pulse that arrives while a frame or its gap is still running (busy_o high) is dropped. It causes no later frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Requests one frame in single-shot mode |
| cont_i | input | 1 | Selects continuous mode (paced by period_i) |
| div_i | input | DIV_W | Serial-clock half period, in system clocks |
| period_i | input | PER_W | Spacing of frame starts, in system clocks |
| sdata_i | input | 1 | Serial data returned by the converter |
| cs_n_o | output | 1 | Active-low select; its falling edge starts a conversion |
| sclk_o | output | 1 | Serial clock, idles high |
| result_o | output | 12 | Last converted value |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| frame_err_o | output | 1 | Leading-zero violation, pulsed with valid_o |
| cfg_err_o | output | 1 | Current div/period setting is rejected |
| busy_o | output | 1 | A frame or its mandatory gap is in progress |

## Verification
The bench drives a behavioural converter that shifts out a random word. It times every select and serial-clock edge in system clocks. The setting with div = 1 needs the acquisition window, not the quiet window, to set the gap: a design that rounded the 36 ns term up would release the next frame one cycle early. A period exactly at the acceptance bound must run, while one cycle less must stall with cfg_err_o raised, which exposes off-by-one errors in the bound. A leading bit forced to one checks that the error is reported and then cleared on the next clean frame. A start pulse placed mid-frame and one placed inside the gap must both be lost, not queued into an extra frame.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;
    localparam int FRAME_BITS = 16;
    localparam int LEAD_BITS  = 4;
    localparam int RES_BITS   = FRAME_BITS - LEAD_BITS;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_SHIFT = 2'd2
    } frame_st_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction
endpackage

// File: rtl/adc_rd_cfg_check.sv
`timescale 1ns/1ps
module adc_rd_cfg_check #(
    parameter int DIV_W       = 8,
    parameter int PER_W       = 16,
    parameter int SETUP_CYC   = 2,
    parameter int QUIET_CYC   = 10,
    parameter int ACQ_NET_CYC = 43
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic [PER_W-1:0] period_i,
    output logic             ok_o,
    output logic [PER_W-1:0] min_gap_o,
    output logic             err_o
);
    // 2.5 serial-clock periods expressed in half periods
    localparam int ACQ_HALVES = 5;

    typedef struct packed {
        logic err;
    } cfg_s;

    cfg_s cur_q, nxt_d;
    int frame_c, acq_gap, gap;

    always_comb begin
        frame_c   = SETUP_CYC + 2 * adc_rd_pkg::FRAME_BITS * int'(div_i);
        acq_gap   = ACQ_NET_CYC - ACQ_HALVES * int'(div_i);
        gap       = (acq_gap > QUIET_CYC) ? acq_gap : QUIET_CYC;
        ok_o      = (div_i != '0) && (int'(period_i) >= frame_c + gap);
        min_gap_o = PER_W'(gap);
        nxt_d     = cur_q;
        nxt_d.err = !ok_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign err_o = cur_q.err;
endmodule

// File: rtl/adc_rd_pacer.sv
`timescale 1ns/1ps
module adc_rd_pacer #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cont_i,
    input  logic             cfg_ok_i,
    input  logic [PER_W-1:0] period_i,
    input  logic [PER_W-1:0] min_gap_i,
    input  logic             idle_i,
    input  logic             end_i,
    output logic             launch_o,
    output logic             busy_o
);
    localparam int CNT_W = PER_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] since_fall;
        logic [CNT_W-1:0] since_rise;
    } pace_s;

    pace_s cur_q, nxt_d;
    logic [CNT_W-1:0] gap_last, per_last;
    logic gap_met, per_met;

    always_comb begin
        gap_last = CNT_W'(min_gap_i) - CNT_W'(1);
        per_last = CNT_W'(period_i) - CNT_W'(1);
        gap_met  = cur_q.since_rise >= gap_last;
        per_met  = cur_q.since_fall >= per_last;
        busy_o   = !idle_i || !gap_met;

        if (cont_i) launch_o = idle_i && cfg_ok_i && gap_met && per_met;
        else        launch_o = idle_i && cfg_ok_i && gap_met && start_i;

        nxt_d = cur_q;
        if (launch_o)                     nxt_d.since_fall = '0;
        else if (cur_q.since_fall != CNT_MAX) nxt_d.since_fall = cur_q.since_fall + 1'b1;
        if (end_i)                        nxt_d.since_rise = '0;
        else if (cur_q.since_rise != CNT_MAX) nxt_d.since_rise = cur_q.since_rise + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.since_fall <= CNT_MAX;
            cur_q.since_rise <= CNT_MAX;
        end else begin
            cur_q <= nxt_d;
        end
    end
endmodule

// File: rtl/adc_rd_frame.sv
`timescale 1ns/1ps
module adc_rd_frame
    import adc_rd_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int SETUP_CYC = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch_i,
    input  logic [DIV_W-1:0]    div_i,
    input  logic                sdata_i,
    output logic                cs_n_o,
    output logic                sclk_o,
    output logic                idle_o,
    output logic                end_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                valid_o,
    output logic                ferr_o
);
    localparam int SC_W  = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;
    localparam int BIT_W = $clog2(FRAME_BITS);
    localparam logic [SC_W-1:0]  SC_LAST  = SC_W'(SETUP_CYC - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

    typedef struct packed {
        frame_st_e             st;
        logic                  cs_n;
        logic                  sclk;
        logic                  hi;
        logic [DIV_W-1:0]      ph;
        logic [DIV_W-1:0]      div;
        logic [BIT_W-1:0]      bitn;
        logic [SC_W-1:0]       scnt;
        logic [FRAME_BITS-1:0] sh;
        logic [RES_BITS-1:0]   res;
        logic                  valid;
        logic                  ferr;
    } frame_s;

    frame_s cur_q, nxt_d;
    logic [DIV_W-1:0] ph_last;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.valid = 1'b0;
        nxt_d.ferr  = 1'b0;
        end_o       = 1'b0;
        ph_last     = cur_q.div - 1'b1;
        case (cur_q.st)
            ST_IDLE: begin
                if (launch_i) begin
                    nxt_d.st   = ST_SETUP;
                    nxt_d.cs_n = 1'b0;
                    nxt_d.scnt = '0;
                    nxt_d.div  = div_i;
                end
            end
            ST_SETUP: begin
                if (cur_q.scnt == SC_LAST) begin
                    // first falling edge: take frame bit 1
                    nxt_d.st   = ST_SHIFT;
                    nxt_d.sclk = 1'b0;
                    nxt_d.hi   = 1'b0;
                    nxt_d.ph   = '0;
                    nxt_d.bitn = '0;
                    nxt_d.sh   = {cur_q.sh[FRAME_BITS-2:0], sdata_i};
                end else begin
                    nxt_d.scnt = cur_q.scnt + 1'b1;
                end
            end
            ST_SHIFT: begin
                if (cur_q.ph == ph_last) begin
                    nxt_d.ph = '0;
                    if (!cur_q.hi) begin
                        nxt_d.sclk = 1'b1;
                        nxt_d.hi   = 1'b1;
                    end else if (cur_q.bitn == BIT_LAST) begin
                        nxt_d.st    = ST_IDLE;
                        nxt_d.cs_n  = 1'b1;
                        nxt_d.valid = 1'b1;
                        nxt_d.res   = cur_q.sh[RES_BITS-1:0];
                        nxt_d.ferr  = |cur_q.sh[FRAME_BITS-1 -: LEAD_BITS];
                        end_o       = 1'b1;
                    end else begin
                        nxt_d.sclk = 1'b0;
                        nxt_d.hi   = 1'b0;
                        nxt_d.bitn = cur_q.bitn + 1'b1;
                        nxt_d.sh   = {cur_q.sh[FRAME_BITS-2:0], sdata_i};
                    end
                end else begin
                    nxt_d.ph = cur_q.ph + 1'b1;
                end
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q      <= '0;
            cur_q.cs_n <= 1'b1;
            cur_q.sclk <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cs_n_o   = cur_q.cs_n;
    assign sclk_o   = cur_q.sclk;
    assign idle_o   = (cur_q.st == ST_IDLE);
    assign result_o = cur_q.res;
    assign valid_o  = cur_q.valid;
    assign ferr_o   = cur_q.ferr;
endmodule

// File: rtl/adc_rd_ctrl.sv
`timescale 1ns/1ps
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int PER_W    = 16,
    parameter int CLK_PS   = 5000,
    parameter int SETUP_PS = 10000,
    parameter int QUIET_PS = 50000,
    parameter int ACQ_PS   = 250000,
    parameter int RELQ_PS  = 36000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                cont_i,
    input  logic [DIV_W-1:0]    div_i,
    input  logic [PER_W-1:0]    period_i,
    input  logic                sdata_i,
    output logic                cs_n_o,
    output logic                sclk_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                valid_o,
    output logic                frame_err_o,
    output logic                cfg_err_o,
    output logic                busy_o
);
    localparam int SETUP_CYC   = ceil_div(SETUP_PS, CLK_PS);
    localparam int QUIET_CYC   = ceil_div(QUIET_PS, CLK_PS);
    // acquisition minus the data-line release time; whole sclk halves are exact cycles
    localparam int ACQ_NET_CYC = ceil_div(ACQ_PS - RELQ_PS, CLK_PS);

    logic             cfg_ok;
    logic [PER_W-1:0] min_gap;
    logic             launch, idle, frame_end;

    adc_rd_cfg_check #(
        .DIV_W(DIV_W), .PER_W(PER_W), .SETUP_CYC(SETUP_CYC),
        .QUIET_CYC(QUIET_CYC), .ACQ_NET_CYC(ACQ_NET_CYC)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .div_i(div_i), .period_i(period_i),
        .ok_o(cfg_ok), .min_gap_o(min_gap), .err_o(cfg_err_o)
    );

    adc_rd_pacer #(.PER_W(PER_W)) u_pace (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i),
        .cfg_ok_i(cfg_ok), .period_i(period_i), .min_gap_i(min_gap),
        .idle_i(idle), .end_i(frame_end), .launch_o(launch), .busy_o(busy_o)
    );

    adc_rd_frame #(.DIV_W(DIV_W), .SETUP_CYC(SETUP_CYC)) u_frame (
        .clk(clk), .rst_n(rst_n), .launch_i(launch), .div_i(div_i),
        .sdata_i(sdata_i), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .idle_o(idle),
        .end_o(frame_end), .result_o(result_o), .valid_o(valid_o),
        .ferr_o(frame_err_o)
    );
endmodule

// File: rtl/adc_rd_checker.sv
`timescale 1ns/1ps
module adc_rd_checker #(
    parameter int CLK_PS   = 5000,
    parameter int QUIET_PS = 50000
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n_o,
    input logic sclk_o,
    input logic valid_o,
    input logic frame_err_o,
    input logic cfg_err_o,
    input logic busy_o
);
    localparam int QUIET_CYC = (QUIET_PS + CLK_PS - 1) / CLK_PS;
    localparam logic [15:0] HI_MAX = '1;

    logic [15:0] hi_cnt_q, hi_cnt_d;

    always_comb begin
        if (!cs_n_o)              hi_cnt_d = '0;
        else if (hi_cnt_q != HI_MAX) hi_cnt_d = hi_cnt_q + 1'b1;
        else                      hi_cnt_d = hi_cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hi_cnt_q <= HI_MAX;
        else        hi_cnt_q <= hi_cnt_d;
    end

    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o);

    p_valid_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cs_n_o && !$past(cs_n_o)));

    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_ferr_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |-> valid_o);

    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> (int'(hi_cnt_q) >= QUIET_CYC));

    p_fall_cfg_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> !cfg_err_o);

    p_busy_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> busy_o);
endmodule

bind adc_rd_ctrl adc_rd_checker #(.CLK_PS(CLK_PS), .QUIET_PS(QUIET_PS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
    .valid_o(valid_o), .frame_err_o(frame_err_o), .cfg_err_o(cfg_err_o),
    .busy_o(busy_o)
);

// File: tb/adc_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_rd_ctrl_tb_top;
    localparam int SETUP_EXP = 2;   // 10 ns at a 5 ns clock

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cont = 1'b0;
    logic [7:0]  div = 8'd1;
    logic [15:0] period = 16'd200;
    logic sdata = 1'bz;
    logic cs_n, sclk, valid, ferr, cfg_err, busy;
    logic [11:0] result;

    int n_chk = 0, n_bad = 0;
    longint cyc = 0;

    always #2.5 clk = ~clk;

    adc_rd_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cont_i(cont),
        .div_i(div), .period_i(period), .sdata_i(sdata), .cs_n_o(cs_n),
        .sclk_o(sclk), .result_o(result), .valid_o(valid),
        .frame_err_o(ferr), .cfg_err_o(cfg_err), .busy_o(busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_gap(input int d);
        for (int k = 1; k < 1000; k++)
            if (k * 5 >= 50 && 25 * d + 36 + 5 * k >= 250) return k;
        return 0;
    endfunction

    // behavioural converter
    logic [3:0]  lead_inj = 4'd0;
    logic [15:0] word;
    int          idx;
    logic [12:0] exp_q[$];

    always @(negedge cs_n) begin
        word = {lead_inj, 12'($urandom)};
        exp_q.push_back({|lead_inj, word[11:0]});
        idx = 0;
        sdata <= #1 word[15];
    end
    always @(negedge sclk) if (!cs_n) begin
        idx++;
        if (idx < 16) sdata <= #1 word[15 - idx];
        else          sdata <= #1 1'bz;
    end
    always @(posedge cs_n) sdata <= #1 1'bz;

    // timing monitor
    logic   prev_cs = 1'b1, prev_sclk = 1'b1, prev_valid = 1'b0;
    longint lo_start = 0, last_edge = 0, rise_cyc = 0, last_fall = -1;
    bit     have_rise = 0, gap_exact = 0, spacing_on = 0;
    int     falls = 0, frames = 0, valids = 0;
    logic [12:0] e;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(!(cs_n && !sclk), "R2", "sclk high while cs high", sclk, 1);
            if (prev_cs && !cs_n) begin
                if (have_rise) begin
                    chk(cyc - rise_cyc >= exp_gap(div), "R7", "min cs high gap", cyc - rise_cyc, exp_gap(div));
                    if (gap_exact)
                        chk(cyc - rise_cyc == exp_gap(div), "R7", "exact gap", cyc - rise_cyc, exp_gap(div));
                end
                if (spacing_on && last_fall >= 0)
                    chk(cyc - last_fall == period, "R8", "fall spacing", cyc - last_fall, period);
                last_fall = cyc; lo_start = cyc; last_edge = cyc; falls = 0; frames++;
            end
            if (!cs_n && !prev_cs && prev_sclk && !sclk) begin
                falls++;
                if (falls == 1)
                    chk(cyc - lo_start == SETUP_EXP, "R3", "setup to first fall", cyc - lo_start, SETUP_EXP);
                else
                    chk(cyc - last_edge == div, "R3", "high phase", cyc - last_edge, div);
                last_edge = cyc;
            end
            if (!cs_n && !prev_sclk && sclk) begin
                chk(cyc - last_edge == div, "R3", "low phase", cyc - last_edge, div);
                last_edge = cyc;
            end
            if (!prev_cs && cs_n) begin
                chk(cyc - lo_start == SETUP_EXP + 32 * div, "R2", "cs low length", cyc - lo_start, SETUP_EXP + 32 * div);
                chk(falls == 16, "R2", "sclk falls", falls, 16);
                chk(cyc - last_edge == div, "R3", "last high phase", cyc - last_edge, div);
                chk(valid == 1'b1, "R5", "valid at cs rise", valid, 1);
                rise_cyc = cyc; have_rise = 1;
            end
            if (valid) begin
                valids++;
                chk(!prev_valid, "R5", "valid single cycle", prev_valid, 0);
                if (exp_q.size() == 0) chk(0, "R4", "unexpected result", 1, 0);
                else begin
                    e = exp_q.pop_front();
                    chk(result == e[11:0], "R4", "result", result, e[11:0]);
                    chk(ferr == e[12], "R6", "frame error flag", ferr, e[12]);
                end
            end else begin
                chk(!ferr, "R6", "frame error outside valid", ferr, 0);
            end
        end
        prev_cs = cs_n; prev_sclk = sclk; prev_valid = valid;
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask
    task automatic wait_valids(input int n);
        int target = valids + n;
        while (valids < target) @(negedge clk);
    endtask
    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog (all requirements): actual %0d expected below 150000", cyc);
        summary();
        $finish;
    end

    int f0, v0;
    initial begin
        // R1: reset state
        wait_cyc(3);
        chk(cs_n == 1'b1, "R1", "cs during reset", cs_n, 1);
        chk(sclk == 1'b1, "R1", "sclk during reset", sclk, 1);
        chk(valid == 1'b0, "R1", "valid during reset", valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b1 && !valid, "R1", "idle after reset", {cs_n, sclk, valid}, 3'b110);
        chk(cfg_err == 1'b0, "R9", "default config accepted", cfg_err, 0);

        // single shot, div 1 (R2 R3 R4 R5)
        pulse_start();
        wait_valids(1);
        wait_cyc(60);

        // start held: gap set by acquisition window (R7)
        start = 1'b1;
        wait_valids(1);
        gap_exact = 1;
        wait_valids(3);
        start = 1'b0; gap_exact = 0;
        wait_cyc(60);

        // framing error then clean frame, div 4 (R6)
        div = 8'd4; period = 16'd300;
        lead_inj = 4'b0010;
        pulse_start();
        wait_valids(1);
        lead_inj = 4'b0000;
        wait_cyc(40);
        pulse_start();
        wait_valids(1);
        wait_cyc(40);

        // continuous mode, div 2 period 120 (R8)
        div = 8'd2; period = 16'd120;
        spacing_on = 1; last_fall = -1;
        cont = 1'b1;
        wait_valids(4);
        cont = 1'b0; spacing_on = 0;
        wait_cyc(60);

        // reject one below the bound, div 8 (R9)
        div = 8'd8; period = 16'd267;
        cont = 1'b1;
        wait_cyc(2);
        chk(cfg_err == 1'b1, "R9", "period below bound rejected", cfg_err, 1);
        f0 = frames;
        wait_cyc(600);
        chk(frames == f0, "R9", "no frame while rejected", frames - f0, 0);
        div = 8'd0;
        wait_cyc(2);
        chk(cfg_err == 1'b1, "R9", "zero divider rejected", cfg_err, 1);
        wait_cyc(100);
        chk(frames == f0, "R9", "no frame with zero divider", frames - f0, 0);

        // exactly at the bound: accepted, gap at quiet minimum (R9 R8 R7)
        div = 8'd8; period = 16'd268;
        spacing_on = 1; last_fall = -1;
        wait_cyc(2);
        chk(cfg_err == 1'b0, "R9", "period at bound accepted", cfg_err, 0);
        wait_valids(1);
        gap_exact = 1;
        wait_valids(2);
        cont = 1'b0; spacing_on = 0; gap_exact = 0;
        wait_cyc(300);

        // start dropped mid frame and inside the gap (R10)
        div = 8'd3; period = 16'd300;
        f0 = frames; v0 = valids;
        pulse_start();
        wait_cyc(20);
        chk(busy == 1'b1, "R10", "busy during frame", busy, 1);
        pulse_start();
        wait_valids(1);
        wait_cyc(5);
        chk(busy == 1'b1, "R10", "busy inside gap", busy, 1);
        pulse_start();
        wait_cyc(400);
        chk(frames - f0 == 1, "R10", "frames after dropped starts", frames - f0, 1);
        chk(valids - v0 == 1, "R10", "results after dropped starts", valids - v0, 1);
        chk(busy == 1'b0, "R10", "idle afterwards", busy, 0);

        summary();
        $finish;
    end
endmodule